// File: doc/BRIEF.md
# Segment Descriptor Checker

This block stands beside one segment register of a protected-mode address unit. When software loads a new 16-bit selector, the block splits it into a table index, a table choice and a requested privilege level. It then reads the 8-byte descriptor for that selector as two 32-bit words over a request/valid memory port. It decodes the base, limit, granularity and access fields and keeps them in a hidden cache register. Ordinary accesses never read the table again.

Each access presents an offset and a read/write flag. One cycle later the block returns either the 32-bit linear address (base plus offset) or a protection fault with a cause code. The checks cover a segment that is absent or unusable, a privilege mismatch, an offset beyond the scaled limit, and a write to a segment that does not allow writes. The null selector can be loaded without a memory read, but any access through it faults.

Top module: `seg_desc_checker`

## Requirements
- R1: Selector bits 15:3 are the descriptor index and bit 2 picks the table (0: `gdt_base_i`, 1: `ldt_base_i`). Bits 1:0 are the requested privilege level (RPL). A fetch reads the word at table base + index×8, then the word at that address + 4. `mem_req_o` and `mem_addr_o` are held until a cycle with `mem_rvalid_i` high, in which the data word is taken.
- R2: Descriptor layout. Low word: limit[15:0] in bits 15:0 and base[15:0] in bits 31:16. High word: base[23:16] in bits 7:0, type in 11:8, S in 12, DPL in 14:13, present P in 15, limit[19:16] in 19:16, G in 23, and base[31:24] in 31:24.
- R3: The cached descriptor changes only at the edge where the second word arrives. An access made during a fetch is checked against the previous descriptor. A `load_i` seen while `busy_o` is high is ignored.
- R4: A selector with index 0 and bit 2 clear is null. Loading it issues no memory read and leaves `busy_o` low, and every later access faults with code 1.
- R5: A descriptor with P=0 makes every access fault with code 1. The same code applies after reset, before any load. A faulting access drives `lin_addr_o` to 0.
- R6: With G=0 the effective limit is the 20-bit limit. With G=1 it is limit×4096+4095. An offset equal to the effective limit passes; a larger offset faults with code 2.
- R7: An access faults with code 3 when the loaded RPL is numerically greater than the DPL. RPL equal to or below the DPL passes.
- R8: A write passes only when S=1, type bit 3 is 0 (data) and type bit 1 is 1 (writable); any other write faults with code 4. Reads are not affected by these bits.
- R9: An access sampled with `acc_valid_i` at one edge is reported right after that edge. Either `acc_ok_o` is high with `lin_addr_o` = base + offset modulo 2^32, or `acc_fault_o` is high with a nonzero code. In cycles without an access, both flags, the code and the address are 0.
- R10: When several causes apply, the code reports the first that applies in this order: unusable (1), privilege (3), limit (2), write (4).
- R11: After reset `busy_o`, `mem_req_o`, `acc_ok_o` and `acc_fault_o` are 0, and the cache is unusable.
- R12: Accesses never cause memory requests; only a non-null load accepted while idle does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load a new selector |
| sel_i | input | 16 | Selector value |
| gdt_base_i | input | 32 | Byte address of the global table |
| ldt_base_i | input | 32 | Byte address of the local table |
| busy_o | output | 1 | Descriptor fetch in progress |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data word |
| acc_valid_i | input | 1 | Access request |
| acc_write_i | input | 1 | Access is a write |
| acc_off_i | input | 32 | Access offset |
| acc_ok_o | output | 1 | Access passed |
| acc_fault_o | output | 1 | Protection fault |
| flt_code_o | output | 3 | Fault cause: 0 none, 1 unusable, 2 limit, 3 privilege, 4 write |
| lin_addr_o | output | 32 | Linear address of a passing access |

## Verification
An access result is due exactly one edge after the access is sampled. The bench drives each access on a falling edge, removes it on the next falling edge and reads the result there. The following cycle then has to show idle outputs. A descriptor load takes an open-ended number of cycles, since it depends on the memory latency. For this reason the bench polls `busy_o` on falling edges, with a timeout, and only then accesses the segment. The addresses the memory model served are compared with the expected word pair. One directed case places an access and a second load inside the fetch window, and checks both against the old descriptor.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int AW      = 32;
  localparam int SEL_W   = 16;
  localparam int LIM_W   = 20;
  localparam int GRAN_SH = 12;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_ABSENT = 3'd1,
    FLT_LIMIT  = 3'd2,
    FLT_PRIV   = 3'd3,
    FLT_WRITE  = 3'd4
  } flt_e;

  typedef struct packed {
    logic [AW-1:0] base;
    logic [AW-1:0] lim;
    logic [1:0]    dpl;
    logic [1:0]    rpl;
    logic          usable;
    logic          wr_ok;
  } seg_cache_t;
endpackage

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] tbl_addr_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          done_o,
  output logic [31:0]   w0_o,
  output logic [31:0]   w1_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} st_e;
  st_e           st_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   w0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      w0_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_LO;
          addr_q <= tbl_addr_i;
        end
        ST_LO: if (mem_rvalid_i) begin
          st_q   <= ST_HI;
          w0_q   <= mem_rdata_i;
          addr_q <= addr_q + AW'(4);
        end
        ST_HI: if (mem_rvalid_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign mem_req_o  = (st_q == ST_LO) || (st_q == ST_HI);
  assign mem_addr_o = addr_q;
  assign done_o     = (st_q == ST_HI) && mem_rvalid_i;
  assign w0_o       = w0_q;
  assign w1_o       = mem_rdata_i;
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import seg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       null_i,
  input  logic [1:0] rpl_i,
  input  logic       commit_i,
  input  logic [31:0] w0_i,
  input  logic [31:0] w1_i,
  output seg_cache_t cache_o
);
  logic [AW-1:0]    d_base;
  logic [LIM_W-1:0] d_lim;
  logic [AW-1:0]    d_eff;
  logic [3:0]       d_type;
  logic             d_s, d_p, d_g;
  logic [1:0]       d_dpl;
  logic [1:0]       rpl_pend_q;
  seg_cache_t       c_q;

  assign d_base = {w1_i[31:24], w1_i[7:0], w0_i[31:16]};
  assign d_lim  = {w1_i[19:16], w0_i[15:0]};
  assign d_g    = w1_i[23];
  assign d_p    = w1_i[15];
  assign d_dpl  = w1_i[14:13];
  assign d_s    = w1_i[12];
  assign d_type = w1_i[11:8];

  // scaled limit precomputed at load to keep the access path short
  assign d_eff = d_g ? {d_lim[AW-GRAN_SH-1:0], {GRAN_SH{1'b1}}}
                     : {{(AW-LIM_W){1'b0}}, d_lim};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rpl_pend_q <= '0;
      c_q        <= '0;
    end else begin
      if (start_i) rpl_pend_q <= rpl_i;
      if (null_i) begin
        c_q.usable <= 1'b0;
        c_q.rpl    <= rpl_i;
      end else if (commit_i) begin
        c_q.base   <= d_base;
        c_q.lim    <= d_eff;
        c_q.dpl    <= d_dpl;
        c_q.rpl    <= rpl_pend_q;
        c_q.usable <= d_p;
        c_q.wr_ok  <= d_s && !d_type[3] && d_type[1];
      end
    end
  end

  assign cache_o = c_q;
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          write_i,
  input  logic [AW-1:0] off_i,
  input  seg_cache_t    cache_i,
  output logic          ok_o,
  output logic          fault_o,
  output logic [2:0]    code_o,
  output logic [AW-1:0] lin_o
);
  flt_e          code;
  logic          ok_q, fault_q;
  flt_e          code_q;
  logic [AW-1:0] lin_q;

  always_comb begin
    if (!cache_i.usable)                code = FLT_ABSENT;
    else if (cache_i.rpl > cache_i.dpl) code = FLT_PRIV;
    else if (off_i > cache_i.lim)       code = FLT_LIMIT;
    else if (write_i && !cache_i.wr_ok) code = FLT_WRITE;
    else                                code = FLT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q    <= 1'b0;
      fault_q <= 1'b0;
      code_q  <= FLT_NONE;
      lin_q   <= '0;
    end else begin
      ok_q    <= valid_i && (code == FLT_NONE);
      fault_q <= valid_i && (code != FLT_NONE);
      code_q  <= valid_i ? code : FLT_NONE;
      lin_q   <= (valid_i && code == FLT_NONE) ? cache_i.base + off_i : '0;
    end
  end

  assign ok_o    = ok_q;
  assign fault_o = fault_q;
  assign code_o  = code_q;
  assign lin_o   = lin_q;
endmodule

// File: rtl/seg_desc_checker.sv
module seg_desc_checker
  import seg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [15:0]   sel_i,
  input  logic [31:0]   gdt_base_i,
  input  logic [31:0]   ldt_base_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic [31:0]   mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  input  logic          acc_valid_i,
  input  logic          acc_write_i,
  input  logic [31:0]   acc_off_i,
  output logic          acc_ok_o,
  output logic          acc_fault_o,
  output logic [2:0]    flt_code_o,
  output logic [31:0]   lin_addr_o
);
  logic          load_acc, is_null, start;
  logic [AW-1:0] tbl_base, tbl_addr;
  logic          done;
  logic [31:0]   w0, w1;
  seg_cache_t    cache;

  assign load_acc = load_i && !busy_o;
  assign is_null  = (sel_i[SEL_W-1:3] == '0) && !sel_i[2];
  assign start    = load_acc && !is_null;
  assign tbl_base = sel_i[2] ? ldt_base_i : gdt_base_i;
  assign tbl_addr = tbl_base + {{(AW-SEL_W){1'b0}}, sel_i[SEL_W-1:3], 3'b000};

  seg_desc_fetch u_fetch (
    .clk_i, .rst_ni,
    .start_i      (start),
    .tbl_addr_i   (tbl_addr),
    .busy_o       (busy_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .done_o       (done),
    .w0_o         (w0),
    .w1_o         (w1)
  );

  seg_desc_cache u_cache (
    .clk_i, .rst_ni,
    .start_i  (start),
    .null_i   (load_acc && is_null),
    .rpl_i    (sel_i[1:0]),
    .commit_i (done),
    .w0_i     (w0),
    .w1_i     (w1),
    .cache_o  (cache)
  );

  seg_access_check u_chk (
    .clk_i, .rst_ni,
    .valid_i (acc_valid_i),
    .write_i (acc_write_i),
    .off_i   (acc_off_i),
    .cache_i (cache),
    .ok_o    (acc_ok_o),
    .fault_o (acc_fault_o),
    .code_o  (flt_code_o),
    .lin_o   (lin_addr_o)
  );
endmodule

// File: rtl/seg_desc_checker_sva.sv
module seg_desc_checker_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        load_i,
  input logic [15:0] sel_i,
  input logic        busy_o,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_rvalid_i,
  input logic        acc_valid_i,
  input logic        acc_ok_o,
  input logic        acc_fault_o,
  input logic [2:0]  flt_code_o,
  input logic [31:0] lin_addr_o
);
  // R1
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));
  // R3
  load_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !mem_rvalid_i |=> busy_o);
  // R4
  null_no_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !busy_o && sel_i[15:2] == 14'd0 |=> !busy_o && !mem_req_o);
  // R5
  fault_lin_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_fault_o |-> lin_addr_o == 32'd0 && flt_code_o != 3'd0);
  // R9
  resp_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ok_o || acc_fault_o) |-> $past(acc_valid_i));
  // R9
  resp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_ok_o && acc_fault_o));
  // R12
  acc_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !busy_o && !load_i |=> !mem_req_o);
endmodule

bind seg_desc_checker seg_desc_checker_sva u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .load_i       (load_i),
  .sel_i        (sel_i),
  .busy_o       (busy_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .acc_valid_i  (acc_valid_i),
  .acc_ok_o     (acc_ok_o),
  .acc_fault_o  (acc_fault_o),
  .flt_code_o   (flt_code_o),
  .lin_addr_o   (lin_addr_o)
);

// File: tb/tb_seg_desc_checker.sv
module tb_seg_desc_checker;
  localparam int LAT   = 2;
  localparam logic [31:0] GDT = 32'h0000_0100;
  localparam logic [31:0] LDT = 32'h0000_0200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [15:0] sel_i = '0;
  logic        busy_o, mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        acc_valid_i = 1'b0, acc_write_i = 1'b0;
  logic [31:0] acc_off_i = '0;
  logic        acc_ok_o, acc_fault_o;
  logic [2:0]  flt_code_o;
  logic [31:0] lin_addr_o;

  int checks = 0, errors = 0, cyc = 0, cnt = 0, rec_n = 0, req_cycles = 0;
  logic [31:0] rec [0:7];
  logic [31:0] mem [0:255];

  always #2.5 clk = ~clk;

  seg_desc_checker dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i, .sel_i,
    .gdt_base_i(GDT), .ldt_base_i(LDT),
    .busy_o, .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .acc_valid_i, .acc_write_i, .acc_off_i,
    .acc_ok_o, .acc_fault_o, .flt_code_o, .lin_addr_o
  );

  // memory model: answers a held request after LAT idle cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid_i = 1'b0; cnt = 0;
    end else if (mem_req_o && cnt == LAT) begin
      mem_rvalid_i = 1'b1;
      mem_rdata_i  = (mem_addr_o < 32'h400) ? mem[mem_addr_o[9:2]] : 32'h0;
      if (rec_n < 8) rec[rec_n] = mem_addr_o;
      rec_n++; cnt = 0;
    end else begin
      mem_rvalid_i = 1'b0;
      cnt = mem_req_o ? cnt + 1 : 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (mem_req_o) req_cycles++;
    if (cyc == 50000) begin
      errors++; checks++;
      $display("FAIL watchdog expired: actual %0d cycles, expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // R2 word layout
  task automatic set_desc(input logic [31:0] a, input logic [31:0] base,
                          input logic [19:0] lim, input logic [3:0] typ,
                          input logic [1:0] dpl, input logic p, input logic g);
    mem[a[9:2]]     = {base[15:0], lim[15:0]};
    mem[a[9:2] + 1] = {base[31:24], g, 3'b100, lim[19:16], p, dpl, 1'b1, typ, base[23:16]};
  endtask

  task automatic do_load(input logic [15:0] s);
    int t;
    @(negedge clk); rec_n = 0; load_i = 1'b1; sel_i = s;
    @(negedge clk); load_i = 1'b0;
    t = 0;
    while (busy_o && t < 200) begin @(negedge clk); t++; end
  endtask

  task automatic do_acc(input logic wr, input logic [31:0] off);
    @(negedge clk); acc_valid_i = 1'b1; acc_write_i = wr; acc_off_i = off;
    @(negedge clk); acc_valid_i = 1'b0; acc_write_i = 1'b0;
  endtask

  typedef struct packed {
    logic [15:0] sel;
    logic        wr;
    logic [31:0] off;
    logic [2:0]  flt;
    logic [31:0] lin;
    logic [31:0] tag;
  } vec_t;

  localparam vec_t VECS [17] = '{
    '{16'h000B, 1'b0, 32'h0000_0FFF, 3'd0, 32'h0010_0FFF, "R6  "},
    '{16'h000B, 1'b0, 32'h0000_1000, 3'd2, 32'h0,         "R6  "},
    '{16'h000B, 1'b1, 32'h0000_0010, 3'd0, 32'h0010_0010, "R8  "},
    '{16'h0010, 1'b0, 32'h0000_3FFF, 3'd0, 32'h0040_3FFF, "R6  "},
    '{16'h0010, 1'b0, 32'h0000_4000, 3'd2, 32'h0,         "R6  "},
    '{16'h0010, 1'b1, 32'h0000_0000, 3'd4, 32'h0,         "R8  "},
    '{16'h0013, 1'b0, 32'h0000_0000, 3'd3, 32'h0,         "R7  "},
    '{16'h0013, 1'b0, 32'h0000_4000, 3'd3, 32'h0,         "R10 "},
    '{16'h001A, 1'b0, 32'h0000_2000, 3'd0, 32'h0000_1000, "R9  "},
    '{16'h001A, 1'b1, 32'h0000_0000, 3'd4, 32'h0,         "R8  "},
    '{16'h0018, 1'b0, 32'hFFFF_FFFF, 3'd0, 32'hFFFF_EFFF, "R7  "},
    '{16'h0020, 1'b0, 32'h0000_0000, 3'd1, 32'h0,         "R5  "},
    '{16'h0023, 1'b0, 32'h0000_0000, 3'd1, 32'h0,         "R10 "},
    '{16'h002D, 1'b0, 32'h0000_0010, 3'd0, 32'h1234_5688, "R1  "},
    '{16'h002E, 1'b0, 32'h0000_0000, 3'd3, 32'h0,         "R7  "},
    '{16'h0000, 1'b0, 32'h0000_0000, 3'd1, 32'h0,         "R4  "},
    '{16'h0003, 1'b1, 32'h0000_0000, 3'd1, 32'h0,         "R4  "}
  };

  initial begin
    logic [15:0] cur_sel;
    int rq;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    set_desc(GDT + 8,  32'h0010_0000, 20'h00FFF, 4'b0010, 2'd3, 1'b1, 1'b0);
    set_desc(GDT + 16, 32'h0040_0000, 20'h00003, 4'b0000, 2'd0, 1'b1, 1'b1);
    set_desc(GDT + 24, 32'hFFFF_F000, 20'hFFFFF, 4'b1010, 2'd2, 1'b1, 1'b1);
    set_desc(GDT + 32, 32'h0000_0000, 20'hFFFFF, 4'b0010, 2'd0, 1'b0, 1'b0);
    set_desc(LDT + 40, 32'h1234_5678, 20'h00010, 4'b0010, 2'd1, 1'b1, 1'b0);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(busy_o, 0, "R11 busy after reset");
    chk(mem_req_o, 0, "R11 req after reset");
    chk({acc_ok_o, acc_fault_o}, 0, "R11 flags after reset");
    do_acc(1'b0, 32'h0);
    chk(flt_code_o, 3'd1, "R11 unusable cache after reset");

    cur_sel = 16'hFFFF;
    foreach (VECS[i]) begin
      if (VECS[i].sel != cur_sel) begin
        cur_sel = VECS[i].sel;
        do_load(cur_sel);
        if (cur_sel[15:2] == 14'd0) begin
          chk(rec_n, 0, "R4 null load reads no memory");
        end else begin
          chk(rec_n, 2, "R1 two words read");
          chk(rec[0], (cur_sel[2] ? LDT : GDT) + {16'h0, cur_sel[15:3], 3'b000}, "R1 low word address");
          chk(rec[1], (cur_sel[2] ? LDT : GDT) + {16'h0, cur_sel[15:3], 3'b100}, "R1 high word address");
        end
      end
      rq = req_cycles;
      do_acc(VECS[i].wr, VECS[i].off);
      chk({31'h0, acc_ok_o}, {31'h0, VECS[i].flt == 3'd0}, $sformatf("%s vec%0d ok", VECS[i].tag, i));
      chk({31'h0, acc_fault_o}, {31'h0, VECS[i].flt != 3'd0}, $sformatf("%s vec%0d fault", VECS[i].tag, i));
      chk(flt_code_o, VECS[i].flt, $sformatf("%s vec%0d code", VECS[i].tag, i));
      chk(lin_addr_o, VECS[i].lin, $sformatf("%s vec%0d linear", VECS[i].tag, i));
      chk(req_cycles, rq, "R12 access made no request");
      @(negedge clk);
      chk({acc_ok_o, acc_fault_o, flt_code_o}, 0, "R9 idle outputs");
      chk(lin_addr_o, 0, "R9 idle address");
    end

    // R3: access and second load during a fetch
    do_load(16'h000B);
    @(negedge clk); rec_n = 0; load_i = 1'b1; sel_i = 16'h0010;
    @(negedge clk); sel_i = 16'h0018;
    acc_valid_i = 1'b1; acc_off_i = 32'h0000_0FFF;
    @(negedge clk); load_i = 1'b0; acc_valid_i = 1'b0;
    chk(busy_o, 1, "R3 fetch still busy");
    chk(lin_addr_o, 32'h0010_0FFF, "R3 old descriptor during fetch");
    chk(acc_ok_o, 1, "R3 old descriptor passes");
    for (int t = 0; t < 200 && busy_o; t++) @(negedge clk);
    chk(rec_n, 2, "R3 second load ignored");
    do_acc(1'b0, 32'h0000_3FFF);
    chk(lin_addr_o, 32'h0040_3FFF, "R3 new descriptor after fetch");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule